// File: doc/BRIEF.md
# USB Device Endpoint Token Responder

This block sits between the token decoder and the packet engine of a USB device controller. It decides how the device answers every host token aimed at one of five IN and five OUT endpoints, endpoint 0 included. Each endpoint keeps a configuration word written through a simple write port. The word holds an enable bit, an activation bit, the transfer type, the maximum packet size, the transmit FIFO selector (IN only), the data toggle, the isochronous frame parity, forced NAK, forced STALL and OUT snoop.

For each decoded token (endpoint, direction, frame-number parity), the block looks at the endpoint's word and at the FIFO flags. One cycle later it reports a reply: nothing, NAK, STALL, send data or receive data. It also reports the DATA0/DATA1 PID to send or expect, the transmit FIFO to read, and whether the received CRC must be checked. A second port reports how each transaction ended: a host ACK for IN, or a received data packet for OUT. The block then decides on the OUT handshake, keeps or drops the data, and advances the data toggle.

Top module: `ep_token_resp`

## Requirements
- R1: After reset every endpoint word is zero, so every endpoint is disabled, and `rsp_valid`, `cmp_ack` and `cmp_keep` are low.
- R2: `rsp_valid` is high exactly one cycle after a cycle with `tok_valid` high. `rsp_code` uses 0 = no reply, 1 = NAK, 2 = STALL, 3 = send data, 4 = receive data. A token for endpoint number 5 or above gets code 0.
- R3: An endpoint whose enable bit or activation bit is clear gets code 0 for tokens and ignores completions.
- R4: On a live endpoint, forced STALL gives code 2 for every token, ahead of all other rules.
- R5: Without STALL, forced NAK gives code 1 whatever the FIFO flags are.
- R6: A bulk or interrupt IN endpoint replies 3 when `txf_ready` at its FIFO selector is high, and 1 otherwise. A selector at or above `NUM_TXF` counts as not ready. On code 3, `rsp_data1` equals the toggle and `rsp_txf` equals the selector. On codes 0 to 2, `rsp_data1` and `rsp_txf` are 0.
- R7: A bulk or interrupt OUT endpoint replies 4 with `rsp_data1` equal to the toggle when `rx_space` is at least its maximum packet size. Otherwise it replies 1.
- R8: An isochronous endpoint answers only when `tok_frame_odd` equals its parity bit: 3 for IN (with `rsp_txf` set), 4 for OUT. It always uses DATA0 (`rsp_data1` = 0) and ignores the FIFO flags. On a parity mismatch it gives code 0.
- R9: `rsp_crc_chk` is high only with code 4, and only when the endpoint's snoop bit is clear.
- R10: An IN completion on a live bulk or interrupt endpoint that is not forced to NAK or STALL flips that endpoint's toggle.
- R11: An OUT completion on a live endpoint without forced NAK or STALL sets `cmp_keep` when `cmp_crc_ok` is high or snoop is set. For bulk or interrupt it also sets `cmp_ack`, and it flips the toggle only when `cmp_pid_odd` equals the toggle. Isochronous keeps the data without ACK. IN completions never raise `cmp_ack` or `cmp_keep`.
- R12: A configuration write to endpoint 5 or above changes nothing. A write and a toggle flip on the same endpoint in the same cycle leave the written value.
- R13: The configuration word layout is: bit 0 enable, bit 1 active, bits 3:2 type (0 bulk, 1 interrupt, 2 isochronous, 3 acts as bulk), bit 4 toggle, bit 5 odd parity, bit 6 forced NAK, bit 7 forced STALL, bit 8 snoop, bits 11:9 FIFO selector, bits 22:12 maximum packet size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_dir | input | 1 | Bank written: 1 IN, 0 OUT |
| cfg_ep | input | 4 | Endpoint written |
| cfg_wdata | input | 23 | Configuration word (layout in R13) |
| tok_valid | input | 1 | Decoded token present |
| tok_dir | input | 1 | Token direction: 1 IN, 0 OUT |
| tok_ep | input | 4 | Token endpoint number |
| tok_frame_odd | input | 1 | Current frame number is odd |
| txf_ready | input | NUM_TXF | Per transmit FIFO: a packet is ready |
| rx_space | input | SPACE_W | Free bytes in the receive FIFO |
| cmp_valid | input | 1 | Transaction completion present |
| cmp_dir | input | 1 | Completion direction: 1 IN, 0 OUT |
| cmp_ep | input | 4 | Completion endpoint number |
| cmp_crc_ok | input | 1 | Received data CRC was good (OUT) |
| cmp_pid_odd | input | 1 | Received data PID was DATA1 (OUT) |
| rsp_valid | output | 1 | Token reply valid |
| rsp_code | output | 3 | Reply code (R2) |
| rsp_data1 | output | 1 | PID to send or expect is DATA1 |
| rsp_txf | output | 3 | Transmit FIFO to read |
| rsp_crc_chk | output | 1 | Check the CRC of the incoming data |
| cmp_ack | output | 1 | Send ACK for the OUT data |
| cmp_keep | output | 1 | Keep the received OUT data |

## Verification
Random configuration words, tokens and completions are mixed. This reaches every path of the priority chain: disabled, stalled, NAKed, FIFO-gated bulk and interrupt, and parity-gated isochronous. It also covers out-of-range endpoint numbers and FIFO selectors. The random flow chains completions into later tokens, so a toggle that fails to flip or flips on a PID mismatch shows up as a wrong PID on the next reply. Directed cases cover the STALL-over-NAK order, a receive space exactly equal to the packet size, snoop accepting a bad CRC, and a write colliding with a flip on the same endpoint.

// File: rtl/ept_pkg.sv
package ept_pkg;

    localparam int MPS_W = 11;
    localparam int TXF_W = 3;
    localparam int CFG_W = 23;

    typedef enum logic [1:0] {
        XF_BULK = 2'd0,
        XF_INTR = 2'd1,
        XF_ISO  = 2'd2,
        XF_RSVD = 2'd3
    } xfer_t;

    typedef enum logic [2:0] {
        RSP_NONE  = 3'd0,
        RSP_NAK   = 3'd1,
        RSP_STALL = 3'd2,
        RSP_DATA  = 3'd3,
        RSP_RECV  = 3'd4
    } rsp_t;

    // Packed MSB first: bit 0 is en, bits 22:12 are mps.
    typedef struct packed {
        logic [MPS_W-1:0] mps;
        logic [TXF_W-1:0] txf;
        logic             snoop;
        logic             stall;
        logic             nak;
        logic             odd;
        logic             tgl;
        xfer_t            typ;
        logic             act;
        logic             en;
    } ep_cfg_t;

    typedef struct packed {
        rsp_t             code;
        logic             data1;
        logic [TXF_W-1:0] txf;
        logic             crc_chk;
    } tok_rsp_t;

    function automatic logic ep_live(ep_cfg_t c);
        return c.en & c.act;
    endfunction

    function automatic logic ep_iso(ep_cfg_t c);
        return c.typ == XF_ISO;
    endfunction

endpackage

// File: rtl/ep_cfg_bank.sv
module ep_cfg_bank
    import ept_pkg::*;
#(
    parameter int NUM_EP = 5,
    parameter int EP_W   = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [EP_W-1:0] wr_ep,
    input  ep_cfg_t         wr_cfg,
    input  logic            flip_en,
    input  logic [EP_W-1:0] flip_ep,
    input  logic [EP_W-1:0] rd_a_ep,
    output ep_cfg_t         rd_a,
    input  logic [EP_W-1:0] rd_b_ep,
    output ep_cfg_t         rd_b
);

    ep_cfg_t regs [NUM_EP];

    // A write to the same endpoint overrides a toggle flip.
    always_ff @(posedge clk) begin
        for (int e = 0; e < NUM_EP; e++) begin
            if (rst) begin
                regs[e] <= '0;
            end else if (wr_en && wr_ep == EP_W'(e)) begin
                regs[e] <= wr_cfg;
            end else if (flip_en && flip_ep == EP_W'(e)) begin
                regs[e].tgl <= ~regs[e].tgl;
            end
        end
    end

    // Out-of-range reads return an all-zero (disabled) word.
    always_comb begin
        rd_a = '0;
        rd_b = '0;
        for (int e = 0; e < NUM_EP; e++) begin
            if (rd_a_ep == EP_W'(e)) rd_a = regs[e];
            if (rd_b_ep == EP_W'(e)) rd_b = regs[e];
        end
    end

endmodule

// File: rtl/ep_tok_decide.sv
module ep_tok_decide
    import ept_pkg::*;
#(
    parameter int NUM_TXF = 6,
    parameter int SPACE_W = 12
) (
    input  logic               dir_in,
    input  logic               ep_ok,
    input  ep_cfg_t            cfg,
    input  logic               frame_odd,
    input  logic [NUM_TXF-1:0] txf_ready,
    input  logic [SPACE_W-1:0] rx_space,
    output tok_rsp_t           rsp
);

    localparam int CMP_W = (SPACE_W > MPS_W) ? SPACE_W : MPS_W;

    logic fifo_rdy;
    logic space_ok;

    always_comb begin
        fifo_rdy = 1'b0;
        for (int i = 0; i < NUM_TXF; i++) begin
            if (cfg.txf == TXF_W'(i)) fifo_rdy = txf_ready[i];
        end
    end

    assign space_ok = CMP_W'(rx_space) >= CMP_W'(cfg.mps);

    // Priority: disabled, STALL, NAK, isochronous parity, FIFO state.
    always_comb begin
        rsp      = '0;
        rsp.code = RSP_NONE;
        if (ep_ok && ep_live(cfg)) begin
            if (cfg.stall) begin
                rsp.code = RSP_STALL;
            end else if (cfg.nak) begin
                rsp.code = RSP_NAK;
            end else if (ep_iso(cfg)) begin
                if (frame_odd == cfg.odd) begin
                    if (dir_in) begin
                        rsp.code = RSP_DATA;
                        rsp.txf  = cfg.txf;
                    end else begin
                        rsp.code    = RSP_RECV;
                        rsp.crc_chk = ~cfg.snoop;
                    end
                end
            end else if (dir_in) begin
                if (fifo_rdy) begin
                    rsp.code  = RSP_DATA;
                    rsp.data1 = cfg.tgl;
                    rsp.txf   = cfg.txf;
                end else begin
                    rsp.code = RSP_NAK;
                end
            end else begin
                if (space_ok) begin
                    rsp.code    = RSP_RECV;
                    rsp.data1   = cfg.tgl;
                    rsp.crc_chk = ~cfg.snoop;
                end else begin
                    rsp.code = RSP_NAK;
                end
            end
        end
    end

endmodule

// File: rtl/ep_cmp_eval.sv
module ep_cmp_eval
    import ept_pkg::*;
(
    input  logic    dir_in,
    input  logic    ep_ok,
    input  ep_cfg_t cfg,
    input  logic    crc_ok,
    input  logic    pid_odd,
    output logic    ack,
    output logic    keep,
    output logic    flip
);

    logic usable;
    logic good;
    logic unused_fields;

    assign unused_fields = ^{cfg.mps, cfg.txf, cfg.odd};

    assign usable = ep_ok & ep_live(cfg) & ~cfg.stall & ~cfg.nak;
    assign good   = crc_ok | cfg.snoop;

    always_comb begin
        ack  = 1'b0;
        keep = 1'b0;
        flip = 1'b0;
        if (dir_in) begin
            flip = usable & ~ep_iso(cfg);
        end else begin
            keep = usable & good;
            ack  = usable & good & ~ep_iso(cfg);
            flip = usable & good & ~ep_iso(cfg) & (pid_odd == cfg.tgl);
        end
    end

endmodule

// File: rtl/ep_token_resp.sv
module ep_token_resp
    import ept_pkg::*;
#(
    parameter int NUM_EP  = 5,
    parameter int EP_W    = 4,
    parameter int NUM_TXF = 6,
    parameter int SPACE_W = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic               cfg_dir,
    input  logic [EP_W-1:0]    cfg_ep,
    input  logic [CFG_W-1:0]   cfg_wdata,
    input  logic               tok_valid,
    input  logic               tok_dir,
    input  logic [EP_W-1:0]    tok_ep,
    input  logic               tok_frame_odd,
    input  logic [NUM_TXF-1:0] txf_ready,
    input  logic [SPACE_W-1:0] rx_space,
    input  logic               cmp_valid,
    input  logic               cmp_dir,
    input  logic [EP_W-1:0]    cmp_ep,
    input  logic               cmp_crc_ok,
    input  logic               cmp_pid_odd,
    output logic               rsp_valid,
    output logic [2:0]         rsp_code,
    output logic               rsp_data1,
    output logic [TXF_W-1:0]   rsp_txf,
    output logic               rsp_crc_chk,
    output logic               cmp_ack,
    output logic               cmp_keep
);

    localparam int NUM_DIR = 2;

    ep_cfg_t  tok_view [NUM_DIR];
    ep_cfg_t  cmp_view [NUM_DIR];
    ep_cfg_t  tok_cfg;
    ep_cfg_t  cmp_cfg;
    tok_rsp_t dec;
    logic     tok_ep_ok;
    logic     cmp_ep_ok;
    logic     c_ack;
    logic     c_keep;
    logic     c_flip;

    assign tok_ep_ok = int'(tok_ep) < NUM_EP;
    assign cmp_ep_ok = int'(cmp_ep) < NUM_EP;

    // Index 0 is the OUT bank, index 1 the IN bank.
    for (genvar d = 0; d < NUM_DIR; d++) begin : g_bank
        ep_cfg_bank #(
            .NUM_EP (NUM_EP),
            .EP_W   (EP_W)
        ) u_bank (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (cfg_we && cfg_dir == 1'(d)),
            .wr_ep   (cfg_ep),
            .wr_cfg  (ep_cfg_t'(cfg_wdata)),
            .flip_en (cmp_valid && cmp_dir == 1'(d) && c_flip),
            .flip_ep (cmp_ep),
            .rd_a_ep (tok_ep),
            .rd_a    (tok_view[d]),
            .rd_b_ep (cmp_ep),
            .rd_b    (cmp_view[d])
        );
    end

    assign tok_cfg = tok_dir ? tok_view[1] : tok_view[0];
    assign cmp_cfg = cmp_dir ? cmp_view[1] : cmp_view[0];

    ep_tok_decide #(
        .NUM_TXF (NUM_TXF),
        .SPACE_W (SPACE_W)
    ) u_decide (
        .dir_in    (tok_dir),
        .ep_ok     (tok_ep_ok),
        .cfg       (tok_cfg),
        .frame_odd (tok_frame_odd),
        .txf_ready (txf_ready),
        .rx_space  (rx_space),
        .rsp       (dec)
    );

    ep_cmp_eval u_cmp (
        .dir_in  (cmp_dir),
        .ep_ok   (cmp_ep_ok),
        .cfg     (cmp_cfg),
        .crc_ok  (cmp_crc_ok),
        .pid_odd (cmp_pid_odd),
        .ack     (c_ack),
        .keep    (c_keep),
        .flip    (c_flip)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid   <= 1'b0;
            rsp_code    <= 3'd0;
            rsp_data1   <= 1'b0;
            rsp_txf     <= '0;
            rsp_crc_chk <= 1'b0;
            cmp_ack     <= 1'b0;
            cmp_keep    <= 1'b0;
        end else begin
            rsp_valid   <= tok_valid;
            rsp_code    <= tok_valid ? dec.code : 3'd0;
            rsp_data1   <= tok_valid & dec.data1;
            rsp_txf     <= tok_valid ? dec.txf : '0;
            rsp_crc_chk <= tok_valid & dec.crc_chk;
            cmp_ack     <= cmp_valid & c_ack;
            cmp_keep    <= cmp_valid & c_keep;
        end
    end

endmodule

// File: rtl/ep_token_resp_chk.sv
module ep_token_resp_chk #(
    parameter int NUM_EP = 5,
    parameter int EP_W   = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            tok_valid,
    input logic            tok_dir,
    input logic [EP_W-1:0] tok_ep,
    input logic            cmp_valid,
    input logic            cmp_dir,
    input logic            rsp_valid,
    input logic [2:0]      rsp_code,
    input logic            rsp_data1,
    input logic [2:0]      rsp_txf,
    input logic            rsp_crc_chk,
    input logic            cmp_ack,
    input logic            cmp_keep
);

    p_rsp_follows_tok_r2: assert property (@(posedge clk) disable iff (rst)
        tok_valid |=> rsp_valid);

    p_rsp_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !tok_valid |=> (!rsp_valid && rsp_code == 3'd0));

    p_bad_ep_silent_r2: assert property (@(posedge clk) disable iff (rst)
        (tok_valid && int'(tok_ep) >= NUM_EP) |=> rsp_code == 3'd0);

    p_data_only_in_r6: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_code == 3'd3) |-> $past(tok_dir));

    p_no_pid_on_handshake_r6: assert property (@(posedge clk) disable iff (rst)
        (rsp_code == 3'd1 || rsp_code == 3'd2 || rsp_code == 3'd0)
            |-> (!rsp_data1 && rsp_txf == 3'd0));

    p_crc_only_recv_r9: assert property (@(posedge clk) disable iff (rst)
        (rsp_code != 3'd4) |-> !rsp_crc_chk);

    p_ack_from_out_r11: assert property (@(posedge clk) disable iff (rst)
        cmp_ack |-> $past(cmp_valid && !cmp_dir));

    p_ack_keeps_r11: assert property (@(posedge clk) disable iff (rst)
        cmp_ack |-> cmp_keep);

endmodule

bind ep_token_resp ep_token_resp_chk #(
    .NUM_EP (NUM_EP),
    .EP_W   (EP_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tok_valid   (tok_valid),
    .tok_dir     (tok_dir),
    .tok_ep      (tok_ep),
    .cmp_valid   (cmp_valid),
    .cmp_dir     (cmp_dir),
    .rsp_valid   (rsp_valid),
    .rsp_code    (rsp_code),
    .rsp_data1   (rsp_data1),
    .rsp_txf     (rsp_txf),
    .rsp_crc_chk (rsp_crc_chk),
    .cmp_ack     (cmp_ack),
    .cmp_keep    (cmp_keep)
);

// File: tb/ep_token_resp_tb.sv
`timescale 1ns/1ps
module ep_token_resp_tb;

    localparam int NEP  = 5;
    localparam int NTXF = 6;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we, cfg_dir;
    logic [3:0]  cfg_ep;
    logic [22:0] cfg_wdata;
    logic        tok_valid, tok_dir, tok_frame_odd;
    logic [3:0]  tok_ep;
    logic [5:0]  txf_ready;
    logic [11:0] rx_space;
    logic        cmp_valid, cmp_dir, cmp_crc_ok, cmp_pid_odd;
    logic [3:0]  cmp_ep;
    logic        rsp_valid, rsp_data1, rsp_crc_chk, cmp_ack, cmp_keep;
    logic [2:0]  rsp_code, rsp_txf;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [22:0] m_cfg [2][NEP];

    always #2 clk = ~clk;

    ep_token_resp u_dut (.*);

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [22:0] mk(input bit en, input bit act, input bit [1:0] typ,
                                       input bit tgl, input bit odd, input bit nak,
                                       input bit stall, input bit snoop,
                                       input bit [2:0] txf, input bit [10:0] mps);
        return {mps, txf, snoop, stall, nak, odd, tgl, typ, act, en};
    endfunction

    function automatic void exp_tok(input bit dir, input int ep, input bit odd,
                                    input bit [5:0] rdy, input int space,
                                    output int code, output int d1, output int txf,
                                    output int crc, output string req);
        logic [22:0] c;
        bit iso;
        code = 0; d1 = 0; txf = 0; crc = 0;
        if (ep >= NEP) begin req = "R2"; return; end
        c   = m_cfg[dir][ep];
        iso = (c[3:2] == 2'd2);
        if (!(c[0] && c[1])) begin req = "R3"; return; end
        if (c[7]) begin code = 2; req = "R4"; return; end
        if (c[6]) begin code = 1; req = "R5"; return; end
        if (iso) begin
            req = "R8";
            if (odd == c[5]) begin
                code = dir ? 3 : 4;
                txf  = dir ? int'(c[11:9]) : 0;
                crc  = dir ? 0 : int'(!c[8]);
            end
            return;
        end
        if (dir) begin
            req = "R6";
            if (c[11:9] < NTXF && rdy[c[11:9]]) begin
                code = 3; d1 = c[4]; txf = c[11:9];
            end else code = 1;
        end else begin
            req = "R7";
            if (space >= int'(c[22:12])) begin
                code = 4; d1 = c[4]; crc = !c[8];
            end else code = 1;
        end
    endfunction

    task automatic do_cfg(input bit dir, input int ep, input logic [22:0] w);
        cfg_we = 1; cfg_dir = dir; cfg_ep = 4'(ep); cfg_wdata = w;
        @(negedge clk);
        cfg_we = 0;
        if (ep < NEP) m_cfg[dir][ep] = w;
    endtask

    task automatic do_tok(input bit dir, input int ep, input bit odd,
                          input bit [5:0] rdy, input int space);
        int code, d1, txf, crc;
        string req;
        exp_tok(dir, ep, odd, rdy, space, code, d1, txf, crc, req);
        tok_valid = 1; tok_dir = dir; tok_ep = 4'(ep); tok_frame_odd = odd;
        txf_ready = rdy; rx_space = 12'(space);
        @(negedge clk);
        tok_valid = 0;
        check("R2 valid", rsp_valid, 1);
        check({req, " code"}, rsp_code, code);
        check({req, " pid"}, rsp_data1, d1);
        check({req, " fifo"}, rsp_txf, txf);
        check("R9 crc", rsp_crc_chk, crc);
    endtask

    // Completion, optionally with a configuration write in the same cycle (R12).
    task automatic do_cmp(input bit dir, input int ep, input bit crc, input bit pid,
                          input bit wr, input logic [22:0] w);
        logic [22:0] c;
        bit usable, good, iso;
        int e_ack, e_keep;
        bit flip;
        e_ack = 0; e_keep = 0; flip = 0;
        if (ep < NEP) begin
            c      = m_cfg[dir][ep];
            iso    = (c[3:2] == 2'd2);
            usable = c[0] && c[1] && !c[6] && !c[7];
            good   = crc || c[8];
            if (dir) flip = usable && !iso;
            else begin
                e_keep = int'(usable && good);
                e_ack  = int'(usable && good && !iso);
                flip   = usable && good && !iso && (pid == c[4]);
            end
        end
        cmp_valid = 1; cmp_dir = dir; cmp_ep = 4'(ep); cmp_crc_ok = crc; cmp_pid_odd = pid;
        if (wr) begin cfg_we = 1; cfg_dir = dir; cfg_ep = 4'(ep); cfg_wdata = w; end
        @(negedge clk);
        cmp_valid = 0; cfg_we = 0;
        check("R11 ack", cmp_ack, e_ack);
        check("R11 keep", cmp_keep, e_keep);
        if (ep < NEP) begin
            if (wr) m_cfg[dir][ep] = w;
            else if (flip) m_cfg[dir][ep][4] = ~m_cfg[dir][ep][4];
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1; cfg_we = 0; cfg_dir = 0; cfg_ep = 0; cfg_wdata = 0;
        tok_valid = 0; tok_dir = 0; tok_ep = 0; tok_frame_odd = 0;
        txf_ready = 0; rx_space = 0;
        cmp_valid = 0; cmp_dir = 0; cmp_ep = 0; cmp_crc_ok = 0; cmp_pid_odd = 0;
        for (int d = 0; d < 2; d++)
            for (int e = 0; e < NEP; e++) m_cfg[d][e] = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1: reset state
        check("R1 rsp_valid", rsp_valid, 0);
        check("R1 cmp_ack", cmp_ack, 0);
        check("R1 cmp_keep", cmp_keep, 0);
        do_tok(1, 0, 0, 6'h3f, 4000);   // R1: disabled after reset
        do_tok(0, 4, 0, 6'h3f, 4000);

        // R4, R5: STALL over NAK over FIFO
        do_cfg(1, 1, mk(1, 1, 0, 0, 0, 1, 1, 0, 2, 64));
        do_tok(1, 1, 0, 6'h3f, 0);
        do_cfg(1, 1, mk(1, 1, 0, 0, 0, 1, 0, 0, 2, 64));
        do_tok(1, 1, 0, 6'h3f, 0);
        // R3: enabled but inactive
        do_cfg(1, 1, mk(1, 0, 0, 0, 0, 0, 0, 0, 2, 64));
        do_tok(1, 1, 0, 6'h3f, 0);

        // R6, R10: bulk IN toggles after host ACK
        do_cfg(1, 2, mk(1, 1, 0, 0, 0, 0, 0, 0, 3, 64));
        do_tok(1, 2, 0, 6'b001000, 0);
        do_tok(1, 2, 0, 6'b110111, 0);
        do_cmp(1, 2, 0, 0, 0, 0);
        do_tok(1, 2, 0, 6'b001000, 0);
        // R6: selector beyond NUM_TXF never ready
        do_cfg(1, 3, mk(1, 1, 1, 0, 0, 0, 0, 0, 7, 64));
        do_tok(1, 3, 0, 6'h3f, 0);

        // R7: space exactly the packet size, then one short
        do_cfg(0, 0, mk(1, 1, 0, 1, 0, 0, 0, 0, 0, 64));
        do_tok(0, 0, 0, 0, 64);
        do_tok(0, 0, 0, 0, 63);
        // R11: PID mismatch ACKs without flip, match flips
        do_cmp(0, 0, 1, 0, 0, 0);
        do_tok(0, 0, 0, 0, 64);
        do_cmp(0, 0, 1, 1, 0, 0);
        do_tok(0, 0, 0, 0, 64);
        do_cmp(0, 0, 0, 0, 0, 0);   // bad CRC dropped

        // R9, R11: snoop accepts bad CRC
        do_cfg(0, 1, mk(1, 1, 1, 0, 0, 0, 0, 1, 0, 8));
        do_tok(0, 1, 0, 0, 8);
        do_cmp(0, 1, 0, 0, 0, 0);

        // R8: isochronous parity
        do_cfg(1, 4, mk(1, 1, 2, 1, 1, 0, 0, 0, 5, 100));
        do_tok(1, 4, 1, 0, 0);
        do_tok(1, 4, 0, 6'h3f, 0);
        do_cfg(0, 4, mk(1, 1, 2, 0, 0, 0, 0, 0, 0, 100));
        do_tok(0, 4, 0, 0, 0);
        do_cmp(0, 4, 1, 0, 0, 0);

        // R12: out-of-range write, write colliding with flip
        do_cfg(1, 5, mk(1, 1, 0, 0, 0, 0, 0, 0, 0, 0));
        do_tok(1, 5, 0, 6'h3f, 0);
        do_cmp(1, 2, 0, 0, 1, mk(1, 1, 0, 0, 0, 0, 0, 0, 3, 64));
        do_tok(1, 2, 0, 6'b001000, 0);

        // Constrained random mix (R2..R13)
        for (int i = 0; i < 3000; i++) begin
            int sel;
            bit dir;
            int ep;
            sel = $urandom % 10;
            dir = 1'($urandom);
            ep  = $urandom % 6;
            if (sel < 2) begin
                do_cfg(dir, ep, mk(($urandom % 8) != 0, ($urandom % 8) != 0,
                                   2'($urandom), 1'($urandom), 1'($urandom),
                                   ($urandom % 6) == 0, ($urandom % 8) == 0,
                                   1'($urandom), 3'($urandom), 11'($urandom % 64)));
            end else if (sel < 7) begin
                do_tok(dir, ep, 1'($urandom), 6'($urandom), $urandom % 96);
            end else begin
                do_cmp(dir, ep, ($urandom % 4) != 0, 1'($urandom),
                       ($urandom % 16) == 0,
                       mk(1, 1, 2'($urandom), 1'($urandom), 0, 0, 0, 0, 3'($urandom), 32));
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule